// File: doc/BRIEF.md
# Four-bit up/down counter with asynchronous transparent load

This block holds a four-bit binary count that steps by one on each rising clock edge while counting is enabled. A direction input chooses between incrementing and decrementing, and the count wraps modulo sixteen in both directions. Two asynchronous level inputs override the clocked path: a clear that forces the count to zero, and a load that makes the count follow a four-bit data input for as long as it is held high.

An active-low terminal count flag is decoded combinationally from the count, the direction and the enable. It goes low when the next enabled edge would wrap the count: the count is all ones while counting up, or all zeros while counting down. Several stages can be chained by feeding this flag into the enable of the next stage.

Top module: `updn_counter`

## Requirements
- R1: While `clr` is 1 the count `q` is 0000 without waiting for a clock edge, whatever `ld`, `din`, `dir_up`, `en_n` and `clk` do.
- R2: While `ld` is 1 and `clr` is 0, `q` equals `din` and follows every change of `din` without a clock edge; clock edges and `en_n` have no effect on `q` during this time.
- R3: When `clr`, `ld` and `en_n` are all 0, each rising edge of `clk` adds one to `q` if `dir_up` is 1 and subtracts one if `dir_up` is 0.
- R4: Counting wraps modulo 16: up from 1111 gives 0000, and down from 0000 gives 1111.
- R5: When `en_n` is 1 and `clr` and `ld` are 0, `q` keeps its value across rising clock edges.
- R6: `tc_n` is 0 exactly when `en_n` is 0 and either `dir_up` is 1 with `q` equal to 1111, or `dir_up` is 0 with `q` equal to 0000; otherwise it is 1.
- R7: `tc_n` responds to changes of `en_n` and `dir_up` with no clock edge in between.
- R8: Priority is clear over load over counting or holding: with `clr` and `ld` both 1, `q` is 0000.
- R9: After `ld` or `clr` is released, the first rising edge with `en_n` at 0 steps from the loaded or cleared value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, rising edge |
| clr | input | 1 | Asynchronous clear, active high, highest priority |
| ld | input | 1 | Asynchronous transparent load, active high |
| din | input | WIDTH | Value the count follows while `ld` is high |
| dir_up | input | 1 | 1 counts up, 0 counts down |
| en_n | input | 1 | Count enable, active low |
| q | output | WIDTH | Current count |
| tc_n | output | 1 | Terminal count, active low |

## Verification
The whole state of the block is the count itself, and it sits directly on `q`, so any wrong internal value appears at the ports in the same cycle it arises and is caught by the next comparison against the reference model. A wrong step direction or a missed wrap shows on `q` one clock after the offending edge, while a faulty asynchronous path (clear or load) shows before the next edge since the count must follow those inputs immediately. A fault in the terminal count decode shows only at the two end values, so the stimulus deliberately parks the count at 1111 and 0000 in both directions with the enable toggled between edges.

// File: rtl/updn_counter.sv
module updn_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             ld,
  input  logic [WIDTH-1:0] din,
  input  logic             dir_up,
  input  logic             en_n,
  output logic [WIDTH-1:0] q,
  output logic             tc_n
);
  logic [WIDTH-1:0] step_val;
  logic [WIDTH-1:0] nxt;
  logic             at_end;

  assign step_val = dir_up ? WIDTH'(1) : {WIDTH{1'b1}};
  assign nxt      = en_n ? q : q + step_val;
  assign at_end   = dir_up ? (&q) : ~(|q);
  assign tc_n     = ~(at_end & ~en_n);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic b_clr;
    logic b_set;
    logic b_q;

    assign b_clr = clr | (ld & ~din[i]);
    assign b_set = ~clr & ld & din[i];

    always_ff @(posedge clk or posedge b_clr or posedge b_set) begin
      if (b_clr)      b_q <= 1'b0;
      else if (b_set) b_q <= 1'b1;
      else            b_q <= nxt[i];
    end

    assign q[i] = b_q;
  end
endmodule

// File: rtl/updn_counter_chk.sv
module updn_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             clr,
  input logic             ld,
  input logic [WIDTH-1:0] din,
  input logic             dir_up,
  input logic             en_n,
  input logic [WIDTH-1:0] q,
  input logic             tc_n
);
  always @(negedge clk) begin
    if (clr) AST_CLEAR_ZERO: assert (q == '0); // R1
  end

  always @(negedge clk) begin
    if (!clr && ld) AST_LOAD_FOLLOWS: assert (q == din); // R2
  end

  always @(negedge clk) begin
    if (clr === 1'b0)
      AST_TC_DECODE: assert (tc_n == !(!en_n && (dir_up ? (q == '1) : (q == '0)))); // R6
  end

  AST_STEP_UP: assert property (@(posedge clk) disable iff (clr)
    (!ld && !en_n && dir_up) |=> (ld || q == WIDTH'($past(q) + 1'b1))); // R3

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (clr)
    (!ld && !en_n && !dir_up) |=> (ld || q == WIDTH'($past(q) - 1'b1))); // R3

  AST_HOLD: assert property (@(posedge clk) disable iff (clr)
    (!ld && en_n) |=> (ld || $stable(q))); // R5
endmodule

bind updn_counter updn_counter_chk #(.WIDTH(WIDTH)) i_chk (
  .clk(clk), .clr(clr), .ld(ld), .din(din), .dir_up(dir_up),
  .en_n(en_n), .q(q), .tc_n(tc_n)
);

// File: tb/test_updn_counter.sv
module test_updn_counter;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       b_clr = 1'b1;
  logic       b_ld = 1'b0;
  logic [3:0] b_din = 4'd0;
  logic       b_up = 1'b1;
  logic       b_en_n = 1'b1;
  logic [3:0] q;
  logic       tc_n;

  logic [3:0] m = 4'd0;
  bit         cur_async = 1'b1;
  bit         prev_async = 1'b1;
  int         errors = 0;
  int         checks = 0;
  bit         finished = 1'b0;

  updn_counter #(.WIDTH(4)) i_updn_counter (
    .clk(clk), .clr(b_clr), .ld(b_ld), .din(b_din), .dir_up(b_up),
    .en_n(b_en_n), .q(q), .tc_n(tc_n)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic exp_tc();
    if (b_en_n) return 1'b1;
    if (b_up) return (m == 4'hF) ? 1'b0 : 1'b1;
    return (m == 4'h0) ? 1'b0 : 1'b1;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cycle(input bit r, input bit l, input logic [3:0] d,
                       input bit u, input bit e);
    string tag;
    @(posedge clk);
    tag = "R5";
    if (!b_clr && !b_ld && !b_en_n) begin
      if (b_up ? (m == 4'hF) : (m == 4'h0)) tag = "R4";
      else if (prev_async) tag = "R9";
      else tag = "R3";
      m = b_up ? 4'(m + 1) : 4'(m - 1);
    end else if (b_ld || b_clr) begin
      tag = "R2";
    end
    #1;
    b_clr = r; b_ld = l; b_din = d; b_up = u; b_en_n = e;
    prev_async = cur_async;
    cur_async = r || l;
    if (r) begin
      m = 4'd0;
      tag = l ? "R8" : "R1";
    end else if (l) begin
      m = d;
      tag = "R2";
    end
    @(negedge clk);
    chk(q == m, tag, q, m);
    chk(tc_n == exp_tc(), "R6", tc_n, exp_tc());
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1;
    chk(q == 4'd0, "R1", q, 0);
    cycle(1, 0, 4'd7, 1, 0);
    cycle(1, 0, 4'd3, 0, 0);
    cycle(1, 1, 4'd9, 1, 0);
    cycle(0, 1, 4'd5, 1, 0);
    cycle(0, 1, 4'd6, 1, 0);
    for (int k = 0; k < 4; k++) cycle(0, 0, 4'd0, 1, 0);
    cycle(0, 1, 4'd14, 1, 0);
    for (int k = 0; k < 3; k++) cycle(0, 0, 4'd0, 1, 0);
    cycle(0, 1, 4'd1, 0, 0);
    for (int k = 0; k < 3; k++) cycle(0, 0, 4'd0, 0, 0);
    for (int k = 0; k < 3; k++) cycle(0, 0, 4'd9, 0, 1);

    // R2: transparent following between clock edges
    #1 b_ld = 1'b1; b_din = 4'd3; m = 4'd3; cur_async = 1'b1;
    #1 chk(q == 4'd3, "R2", q, 3);
    b_din = 4'd10; m = 4'd10;
    #1 chk(q == 4'd10, "R2", q, 10);
    cycle(0, 1, 4'd10, 1, 0);
    cycle(0, 0, 4'd0, 1, 0);

    // R7: terminal count reacts without a clock edge
    cycle(0, 1, 4'd15, 1, 1);
    cycle(0, 0, 4'd0, 1, 1);
    #1 b_en_n = 1'b0;
    #1 chk(tc_n == 1'b0, "R7", tc_n, 0);
    b_up = 1'b0;
    #1 chk(tc_n == 1'b1, "R7", tc_n, 1);
    #1 b_en_n = 1'b1; b_up = 1'b1;
    cycle(0, 0, 4'd0, 0, 1);
    cycle(0, 1, 4'd0, 0, 1);
    cycle(0, 0, 4'd0, 0, 1);
    #1 b_en_n = 1'b0;
    #1 chk(tc_n == 1'b0, "R7", tc_n, 0);
    #1 b_en_n = 1'b1;

    for (int k = 0; k < 600; k++)
      cycle(($urandom % 25) == 0, ($urandom % 7) == 0, 4'($urandom),
            ($urandom % 3) != 0, ($urandom % 5) == 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule